// File: doc/BRIEF.md
# SPI Master Configuration Register File

This block is the software-visible register bank that sits in front of an SPI master's shift engine. A simple 32-bit bus (address, write strobe, write data, read data) reaches a control word, a frame size, a clock divider, a 32-bit frame count split over two locations and a target-select register. Every stored field is also driven straight out to the shift engine as a configuration signal.

Some configuration must not move while a transfer may be running. Frame size, both halves of the frame count and the clock-mode bit therefore accept writes only while the enable bit, as it stood before the write, is clear. Any other field stays writable at all times, so software can drop the enable bit and change those fields in the same write. Engine status, received data and raw interrupt flags are produced elsewhere and only read back here. The masked interrupt view is the raw flags gated by the enable bits held in the control word.

Top module: `spi_cfg_regs`

## Requirements
- R1: After reset the control word (offset 0x00) reads 0x8000_0000, with only the soft-reset bit 31 set. Every other stored field reads 0, and every configuration output is 0 apart from the soft-reset output.
- R2: A write to offset 0x00 updates its ungated fields whatever the enable state: enable bit 0, master bit 1, protocol bits 3:2, interrupt enables bits 7:4, idle-high clock bit 24, late-phase bit 25, select-hold bit 26, deep-FIFO bit 29 and soft reset bit 31. The new value is visible on the clock edge that ends the write cycle.
- R3: Frame size sits at offset 0x04 in bits 5:0. A write there is dropped while enable is 1.
- R4: The low half of the frame count is written through control bits 23:8. Those bits keep their old value when a control write arrives while enable is 1.
- R5: Offset 0x50 reads the whole 32-bit frame count, with the upper half in bits 31:16 and the lower half in bits 15:0. A write there loads only bits 31:16 and leaves the lower half unchanged. The write is dropped while enable is 1.
- R6: The clock-mode bit (control bit 28) keeps its old value when a control write arrives while enable is 1.
- R7: The clock divider sits at offset 0x18 in bits 7:0 and is writable at any time.
- R8: The select register sits at offset 0x1C and is writable at any time. Bits 7:0 hold per-target select bits, bit 8 enables direct software control of the select lines, and bit 9 enables the select output.
- R9: Reserved bits read as 0 and ignore writes. In the control word these are bits 27 and 30; in the other registers they are every bit above the defined fields.
- R10: Engine status is read at offset 0x08 (bits 14:0), received data at 0x10 (bits 15:0) and raw interrupt flags at 0x24 (bit 0 transmit done, bit 1 receive ready, bit 2 receive overflow, bit 3 transmit underrun). Offset 0x20 returns the raw flags gated by their enables: flag 0 by control bit 5, flag 1 by bit 4, flag 2 by bit 6, flag 3 by bit 7. Writes to these offsets, to 0x0C, to 0x14 or to an unmapped address change no register, and unmapped addresses read 0.
- R11: Each configuration output always equals the register field it comes from, and the frame-count output is the 32-bit concatenation of the upper and lower halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| eng_status | input | STAT_W | Engine status for readback |
| eng_rx_data | input | RX_W | Received data for readback |
| eng_irq_raw | input | 4 | Raw interrupt flags for readback |
| cfg_enable | output | 1 | Controller enable |
| cfg_master | output | 1 | Master role |
| cfg_proto | output | 2 | Protocol mode, 0 = standard SPI |
| cfg_irq_en | output | 4 | Interrupt enables (rx data, tx data, rx overflow, tx underrun) |
| cfg_frame_count | output | 32 | Frames per transfer |
| cfg_clk_idle_high | output | 1 | Serial clock idles high |
| cfg_clk_late_phase | output | 1 | Sample on the second clock edge |
| cfg_sel_hold | output | 1 | Keep select asserted between frames |
| cfg_clk_mode | output | 1 | Divider mode choice |
| cfg_deep_fifo | output | 1 | Use the deep FIFO arrangement |
| cfg_soft_reset | output | 1 | Hold the engine in reset |
| cfg_frame_size | output | FSZ_W | Bits per frame |
| cfg_clk_div | output | DIV_W | Clock divider value |
| cfg_sel_mask | output | NUM_SEL | Per-target select bits |
| cfg_sel_direct | output | 1 | Software drives select lines directly |
| cfg_sel_oe | output | 1 | Select output enable |

## Verification
Reads are combinational, so a read result is due in the same cycle the address is presented. The bench drives the address on a falling edge and samples read data shortly after it. A write is presented for one rising edge and its effect appears on that edge. The bench's reference model therefore applies each write just after the edge that takes it, and compares every configuration output against the model on each falling edge. Gating is judged on the enable value held before the write, which the model keeps apart from the incoming data, so enabling and disabling writes are checked on the exact edge where they land.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    // Byte offsets decoded by software.
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_FSIZE = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_ICLR  = 8'h0C;
    localparam logic [7:0] OFS_RXD   = 8'h10;
    localparam logic [7:0] OFS_TXD   = 8'h14;
    localparam logic [7:0] OFS_DIV   = 8'h18;
    localparam logic [7:0] OFS_SEL   = 8'h1C;
    localparam logic [7:0] OFS_IMSK  = 8'h20;
    localparam logic [7:0] OFS_IRAW  = 8'h24;
    localparam logic [7:0] OFS_CNTHI = 8'h50;

    // Raw interrupt flag positions.
    localparam int IRQ_TXDONE = 0;
    localparam int IRQ_RXRDY  = 1;
    localparam int IRQ_RXOVF  = 2;
    localparam int IRQ_TXUND  = 3;

    // Enable positions inside ctrl_t.irq_en (control bits 7:4).
    localparam int IEN_RXDATA = 0;
    localparam int IEN_TXDATA = 1;
    localparam int IEN_RXOVF  = 2;
    localparam int IEN_TXUND  = 3;

    // Select register field positions.
    localparam int SEL_DIRECT_BIT = 8;
    localparam int SEL_OE_BIT     = 9;

    typedef struct packed {
        logic        srst;
        logic        deep;
        logic        clk_mode;
        logic        hold;
        logic        late_phase;
        logic        idle_high;
        logic [15:0] cnt_lo;
        logic [3:0]  irq_en;
        logic [1:0]  proto;
        logic        master;
        logic        en;
    } ctrl_t;

    typedef enum logic [3:0] {
        RS_NONE, RS_CTRL, RS_FSIZE, RS_STAT, RS_RXD,
        RS_DIV, RS_SEL, RS_IMSK, RS_IRAW, RS_CNTHI
    } rsel_e;

    function automatic ctrl_t ctrl_reset_value();
        ctrl_t c;
        c      = '0;
        c.srst = 1'b1;
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.en;
        w[1]     = c.master;
        w[3:2]   = c.proto;
        w[7:4]   = c.irq_en;
        w[23:8]  = c.cnt_lo;
        w[24]    = c.idle_high;
        w[25]    = c.late_phase;
        w[26]    = c.hold;
        w[28]    = c.clk_mode;
        w[29]    = c.deep;
        w[31]    = c.srst;
        return w;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.en         = w[0];
        c.master     = w[1];
        c.proto      = w[3:2];
        c.irq_en     = w[7:4];
        c.cnt_lo     = w[23:8];
        c.idle_high  = w[24];
        c.late_phase = w[25];
        c.hold       = w[26];
        c.clk_mode   = w[28];
        c.deep       = w[29];
        c.srst       = w[31];
        return c;
    endfunction

endpackage

// File: rtl/spi_cfg_decode.sv
module spi_cfg_decode
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output rsel_e             rsel,
    output logic              wr_ctrl,
    output logic              wr_fsize,
    output logic              wr_div,
    output logic              wr_sel,
    output logic              wr_cnt_hi
);

    always_comb begin
        rsel = RS_NONE;
        case (addr)
            ADDR_W'(OFS_CTRL):  rsel = RS_CTRL;
            ADDR_W'(OFS_FSIZE): rsel = RS_FSIZE;
            ADDR_W'(OFS_STAT):  rsel = RS_STAT;
            ADDR_W'(OFS_RXD):   rsel = RS_RXD;
            ADDR_W'(OFS_DIV):   rsel = RS_DIV;
            ADDR_W'(OFS_SEL):   rsel = RS_SEL;
            ADDR_W'(OFS_IMSK):  rsel = RS_IMSK;
            ADDR_W'(OFS_IRAW):  rsel = RS_IRAW;
            ADDR_W'(OFS_CNTHI): rsel = RS_CNTHI;
            default:            rsel = RS_NONE;
        endcase
    end

    always_comb begin
        wr_ctrl   = we && (rsel == RS_CTRL);
        wr_fsize  = we && (rsel == RS_FSIZE);
        wr_div    = we && (rsel == RS_DIV);
        wr_sel    = we && (rsel == RS_SEL);
        wr_cnt_hi = we && (rsel == RS_CNTHI);
    end

    // R10: at most one register is written per bus cycle
    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_ctrl, wr_fsize, wr_div, wr_sel, wr_cnt_hi}));

    // R10: read-only and unmapped offsets never raise a write strobe
    assert_ro_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel inside {RS_NONE, RS_STAT, RS_RXD, RS_IMSK, RS_IRAW})
        |-> !(wr_ctrl || wr_fsize || wr_div || wr_sel || wr_cnt_hi));

endmodule

// File: rtl/spi_cfg_core.sv
module spi_cfg_core
    import spi_cfg_pkg::*;
#(
    parameter int FSZ_W = 6,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_fsize,
    input  logic             wr_div,
    input  logic             wr_cnt_hi,
    input  logic [31:0]      wdata,
    output ctrl_t            ctrl,
    output logic [15:0]      cnt_hi,
    output logic [FSZ_W-1:0] fsize,
    output logic [DIV_W-1:0] div
);

    typedef struct packed {
        ctrl_t             c;
        logic [15:0]       cnt_hi;
        logic [FSZ_W-1:0]  fsize;
        logic [DIV_W-1:0]  div;
    } core_t;

    core_t st_d, st_q;
    ctrl_t incoming;
    logic  locked;
    logic  unused_rsvd;

    assign unused_rsvd = ^{wdata[27], wdata[30]};
    assign locked      = st_q.c.en;

    always_comb begin
        st_d     = st_q;
        incoming = unpack_ctrl(wdata);
        if (locked) begin
            incoming.cnt_lo   = st_q.c.cnt_lo;
            incoming.clk_mode = st_q.c.clk_mode;
        end
        if (wr_ctrl)              st_d.c      = incoming;
        if (wr_fsize && !locked)  st_d.fsize  = wdata[FSZ_W-1:0];
        if (wr_div)               st_d.div    = wdata[DIV_W-1:0];
        if (wr_cnt_hi && !locked) st_d.cnt_hi = wdata[31:16];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.c      <= ctrl_reset_value();
            st_q.cnt_hi <= '0;
            st_q.fsize  <= '0;
            st_q.div    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl   = st_q.c;
    assign cnt_hi = st_q.cnt_hi;
    assign fsize  = st_q.fsize;
    assign div    = st_q.div;

    // R2: ungated control fields follow the written word
    assert_ctrl_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (st_q.c.en == $past(wdata[0])) && (st_q.c.irq_en == $past(wdata[7:4]))
                    && (st_q.c.srst == $past(wdata[31])) && (st_q.c.deep == $past(wdata[29])));

    // R3: frame size frozen while enabled
    assert_fsize_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fsize && st_q.c.en) |=> $stable(st_q.fsize));

    // R4: low frame count frozen while enabled
    assert_cntlo_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && st_q.c.en) |=> $stable(st_q.c.cnt_lo));

    // R5: upper frame count frozen while enabled
    assert_cnthi_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt_hi && st_q.c.en) |=> $stable(st_q.cnt_hi));

    // R5: a write to the upper location never reaches the lower half
    assert_cnthi_lowhalf_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt_hi && !wr_ctrl) |=> $stable(st_q.c.cnt_lo));

    // R6: clock mode frozen while enabled
    assert_clkmode_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && st_q.c.en) |=> $stable(st_q.c.clk_mode));

    // R7: divider always accepts writes
    assert_div_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_div |=> (st_q.div == $past(wdata[DIV_W-1:0])));

    // R10: no strobe, no change
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl || wr_fsize || wr_div || wr_cnt_hi) |=> $stable(st_q));

endmodule

// File: rtl/spi_cfg_select.sv
module spi_cfg_select #(
    parameter int NUM_SEL = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_sel,
    input  logic [NUM_SEL-1:0] new_mask,
    input  logic               new_direct,
    input  logic               new_oe,
    output logic [NUM_SEL-1:0] sel_mask,
    output logic               sel_direct,
    output logic               sel_oe
);

    typedef struct packed {
        logic [NUM_SEL-1:0] mask;
        logic               direct;
        logic               oe;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (wr_sel) begin
            sel_d.mask   = new_mask;
            sel_d.direct = new_direct;
            sel_d.oe     = new_oe;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_mask   = sel_q.mask;
    assign sel_direct = sel_q.direct;
    assign sel_oe     = sel_q.oe;

    // R8: select register written regardless of enable
    assert_sel_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (sel_q.mask == $past(new_mask)) && (sel_q.direct == $past(new_direct))
                   && (sel_q.oe == $past(new_oe)));

    // R8: select register holds without a write
    assert_sel_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(sel_q));

endmodule

// File: rtl/spi_cfg_rdmux.sv
module spi_cfg_rdmux
    import spi_cfg_pkg::*;
#(
    parameter int FSZ_W   = 6,
    parameter int DIV_W   = 8,
    parameter int NUM_SEL = 8,
    parameter int STAT_W  = 15,
    parameter int RX_W    = 16
) (
    input  rsel_e              rsel,
    input  ctrl_t              ctrl,
    input  logic [15:0]        cnt_hi,
    input  logic [FSZ_W-1:0]   fsize,
    input  logic [DIV_W-1:0]   div,
    input  logic [NUM_SEL-1:0] sel_mask,
    input  logic               sel_direct,
    input  logic               sel_oe,
    input  logic [STAT_W-1:0]  stat,
    input  logic [RX_W-1:0]    rx_data,
    input  logic [3:0]         irq_raw,
    output logic [31:0]        rdata
);

    logic [3:0] irq_masked;

    always_comb begin
        irq_masked[IRQ_TXDONE] = irq_raw[IRQ_TXDONE] & ctrl.irq_en[IEN_TXDATA];
        irq_masked[IRQ_RXRDY]  = irq_raw[IRQ_RXRDY]  & ctrl.irq_en[IEN_RXDATA];
        irq_masked[IRQ_RXOVF]  = irq_raw[IRQ_RXOVF]  & ctrl.irq_en[IEN_RXOVF];
        irq_masked[IRQ_TXUND]  = irq_raw[IRQ_TXUND]  & ctrl.irq_en[IEN_TXUND];
    end

    always_comb begin
        rdata = '0;
        case (rsel)
            RS_CTRL:  rdata = pack_ctrl(ctrl);
            RS_FSIZE: rdata[FSZ_W-1:0] = fsize;
            RS_STAT:  rdata[STAT_W-1:0] = stat;
            RS_RXD:   rdata[RX_W-1:0] = rx_data;
            RS_DIV:   rdata[DIV_W-1:0] = div;
            RS_SEL: begin
                rdata[NUM_SEL-1:0]    = sel_mask;
                rdata[SEL_DIRECT_BIT] = sel_direct;
                rdata[SEL_OE_BIT]     = sel_oe;
            end
            RS_IMSK:  rdata[3:0] = irq_masked;
            RS_IRAW:  rdata[3:0] = irq_raw;
            RS_CNTHI: rdata = {cnt_hi, ctrl.cnt_lo};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
    import spi_cfg_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int FSZ_W   = 6,
    parameter int DIV_W   = 8,
    parameter int NUM_SEL = 8,
    parameter int STAT_W  = 15,
    parameter int RX_W    = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [STAT_W-1:0]  eng_status,
    input  logic [RX_W-1:0]    eng_rx_data,
    input  logic [3:0]         eng_irq_raw,
    output logic               cfg_enable,
    output logic               cfg_master,
    output logic [1:0]         cfg_proto,
    output logic [3:0]         cfg_irq_en,
    output logic [31:0]        cfg_frame_count,
    output logic               cfg_clk_idle_high,
    output logic               cfg_clk_late_phase,
    output logic               cfg_sel_hold,
    output logic               cfg_clk_mode,
    output logic               cfg_deep_fifo,
    output logic               cfg_soft_reset,
    output logic [FSZ_W-1:0]   cfg_frame_size,
    output logic [DIV_W-1:0]   cfg_clk_div,
    output logic [NUM_SEL-1:0] cfg_sel_mask,
    output logic               cfg_sel_direct,
    output logic               cfg_sel_oe
);

    rsel_e       rsel;
    logic        wr_ctrl, wr_fsize, wr_div, wr_sel, wr_cnt_hi;
    ctrl_t       ctrl;
    logic [15:0] cnt_hi;

    spi_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .rsel      (rsel),
        .wr_ctrl   (wr_ctrl),
        .wr_fsize  (wr_fsize),
        .wr_div    (wr_div),
        .wr_sel    (wr_sel),
        .wr_cnt_hi (wr_cnt_hi)
    );

    spi_cfg_core #(.FSZ_W(FSZ_W), .DIV_W(DIV_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_fsize  (wr_fsize),
        .wr_div    (wr_div),
        .wr_cnt_hi (wr_cnt_hi),
        .wdata     (bus_wdata),
        .ctrl      (ctrl),
        .cnt_hi    (cnt_hi),
        .fsize     (cfg_frame_size),
        .div       (cfg_clk_div)
    );

    spi_cfg_select #(.NUM_SEL(NUM_SEL)) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .new_mask   (bus_wdata[NUM_SEL-1:0]),
        .new_direct (bus_wdata[SEL_DIRECT_BIT]),
        .new_oe     (bus_wdata[SEL_OE_BIT]),
        .sel_mask   (cfg_sel_mask),
        .sel_direct (cfg_sel_direct),
        .sel_oe     (cfg_sel_oe)
    );

    spi_cfg_rdmux #(
        .FSZ_W(FSZ_W), .DIV_W(DIV_W), .NUM_SEL(NUM_SEL),
        .STAT_W(STAT_W), .RX_W(RX_W)
    ) u_rdmux (
        .rsel       (rsel),
        .ctrl       (ctrl),
        .cnt_hi     (cnt_hi),
        .fsize      (cfg_frame_size),
        .div        (cfg_clk_div),
        .sel_mask   (cfg_sel_mask),
        .sel_direct (cfg_sel_direct),
        .sel_oe     (cfg_sel_oe),
        .stat       (eng_status),
        .rx_data    (eng_rx_data),
        .irq_raw    (eng_irq_raw),
        .rdata      (bus_rdata)
    );

    assign cfg_enable         = ctrl.en;
    assign cfg_master         = ctrl.master;
    assign cfg_proto          = ctrl.proto;
    assign cfg_irq_en         = ctrl.irq_en;
    assign cfg_frame_count    = {cnt_hi, ctrl.cnt_lo};
    assign cfg_clk_idle_high  = ctrl.idle_high;
    assign cfg_clk_late_phase = ctrl.late_phase;
    assign cfg_sel_hold       = ctrl.hold;
    assign cfg_clk_mode       = ctrl.clk_mode;
    assign cfg_deep_fifo      = ctrl.deep;
    assign cfg_soft_reset     = ctrl.srst;

    // R9: reserved control bits always read zero
    assert_ctrl_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CTRL)) |-> (bus_rdata[27] == 1'b0 && bus_rdata[30] == 1'b0));

    // R10: an unmapped offset reads zero
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(8'h40)) |-> (bus_rdata == 32'h0));

    // R5: the upper count location reads the same count the engine receives
    assert_count_view_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_CNTHI)) |-> (bus_rdata == cfg_frame_count));

endmodule

// File: tb/spi_cfg_regs_tb.sv
module spi_cfg_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [14:0] eng_status = '0;
    logic [15:0] eng_rx_data = '0;
    logic [3:0]  eng_irq_raw = '0;
    logic        cfg_enable, cfg_master, cfg_clk_idle_high, cfg_clk_late_phase;
    logic        cfg_sel_hold, cfg_clk_mode, cfg_deep_fifo, cfg_soft_reset;
    logic        cfg_sel_direct, cfg_sel_oe;
    logic [1:0]  cfg_proto;
    logic [3:0]  cfg_irq_en;
    logic [31:0] cfg_frame_count;
    logic [5:0]  cfg_frame_size;
    logic [7:0]  cfg_clk_div, cfg_sel_mask;

    int n_chk = 0;
    int n_fail = 0;
    logic cmp_on = 1'b0;

    // behavioural reference state
    logic [31:0] m_ctrl;
    logic [5:0]  m_fsize;
    logic [7:0]  m_div;
    logic [9:0]  m_sel;
    logic [15:0] m_cnthi;

    always #5 clk = ~clk;

    spi_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_status(eng_status),
        .eng_rx_data(eng_rx_data), .eng_irq_raw(eng_irq_raw),
        .cfg_enable(cfg_enable), .cfg_master(cfg_master), .cfg_proto(cfg_proto),
        .cfg_irq_en(cfg_irq_en), .cfg_frame_count(cfg_frame_count),
        .cfg_clk_idle_high(cfg_clk_idle_high), .cfg_clk_late_phase(cfg_clk_late_phase),
        .cfg_sel_hold(cfg_sel_hold), .cfg_clk_mode(cfg_clk_mode),
        .cfg_deep_fifo(cfg_deep_fifo), .cfg_soft_reset(cfg_soft_reset),
        .cfg_frame_size(cfg_frame_size), .cfg_clk_div(cfg_clk_div),
        .cfg_sel_mask(cfg_sel_mask), .cfg_sel_direct(cfg_sel_direct), .cfg_sel_oe(cfg_sel_oe)
    );

    task automatic chk(input string tag, input string what, input logic [69:0] got,
                       input logic [69:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return m_ctrl;
            8'h04: return {26'h0, m_fsize};
            8'h08: return {17'h0, eng_status};
            8'h10: return {16'h0, eng_rx_data};
            8'h18: return {24'h0, m_div};
            8'h1C: return {22'h0, m_sel};
            8'h20: return {28'h0, eng_irq_raw[3] & m_ctrl[7], eng_irq_raw[2] & m_ctrl[6],
                           eng_irq_raw[1] & m_ctrl[4], eng_irq_raw[0] & m_ctrl[5]};
            8'h24: return {28'h0, eng_irq_raw};
            8'h50: return {m_cnthi, m_ctrl[23:8]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        logic was_on;
        was_on = m_ctrl[0];
        case (a)
            8'h00: if (was_on) m_ctrl = (d & 32'hA700_00FF) | (m_ctrl & 32'h10FF_FF00);
                   else        m_ctrl = d & 32'hB7FF_FFFF;
            8'h04: if (!was_on) m_fsize = d[5:0];
            8'h18: m_div = d[7:0];
            8'h1C: m_sel = d[9:0];
            8'h50: if (!was_on) m_cnthi = d[31:16];
            default: ;
        endcase
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        model_write(a, d);
        #1 bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        chk(tag, $sformatf("read 0x%02h", a), 70'(bus_rdata), 70'(exp));
    endtask

    task automatic rd_all(input string tag);
        logic [7:0] addrs [14];
        addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                  8'h20, 8'h24, 8'h50, 8'h40, 8'h51, 8'h4C};
        for (int i = 0; i < 14; i++) rd(addrs[i], exp_read(addrs[i]), tag);
    endtask

    // R11: every configuration output is compared with the model on each clock
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R11", "config outputs",
                {cfg_enable, cfg_master, cfg_proto, cfg_irq_en, cfg_frame_count,
                 cfg_clk_idle_high, cfg_clk_late_phase, cfg_sel_hold, cfg_clk_mode,
                 cfg_deep_fifo, cfg_soft_reset, cfg_frame_size, cfg_clk_div,
                 cfg_sel_mask, cfg_sel_direct, cfg_sel_oe},
                {m_ctrl[0], m_ctrl[1], m_ctrl[3:2], m_ctrl[7:4], m_cnthi, m_ctrl[23:8],
                 m_ctrl[24], m_ctrl[25], m_ctrl[26], m_ctrl[28], m_ctrl[29], m_ctrl[31],
                 m_fsize, m_div, m_sel[7:0], m_sel[8], m_sel[9]});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        m_ctrl = 32'h8000_0000; m_fsize = '0; m_div = '0; m_sel = '0; m_cnthi = '0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        cmp_on = 1'b1;

        // R1: reset values
        rd(8'h00, 32'h8000_0000, "R1");
        rd_all("R1");

        // R10: readback of engine-side inputs
        eng_status  = 15'h5A5A;
        eng_rx_data = 16'hBEEF;
        eng_irq_raw = 4'b1011;
        rd(8'h08, 32'h0000_5A5A, "R10");
        rd(8'h24, 32'h0000_000B, "R10");
        rd_all("R10");

        // Configure while disabled
        wr(8'h04, 32'h0000_0008);
        rd(8'h04, 32'h0000_0008, "R3");
        wr(8'h50, 32'hABCD_1234);
        rd(8'h50, 32'hABCD_0000, "R5");
        wr(8'h00, 32'h1012_34F2);
        rd(8'h00, 32'h1012_34F2, "R2");
        rd(8'h50, 32'hABCD_1234, "R4");

        // Enable in the same write that sets count and clock mode: accepted
        wr(8'h00, 32'h3512_34A1);
        rd(8'h00, 32'h3512_34A1, "R2");

        // While enabled: gated fields hold, others move
        wr(8'h00, 32'h0598_7653);
        rd(8'h00, 32'h1512_3453, "R4");
        rd(8'h00, 32'h1512_3453, "R6");
        wr(8'h04, 32'h0000_001F);
        rd(8'h04, 32'h0000_0008, "R3");
        wr(8'h50, 32'h7777_0000);
        rd(8'h50, 32'hABCD_1234, "R5");
        wr(8'h18, 32'h0000_01C3);
        rd(8'h18, 32'h0000_00C3, "R7");
        wr(8'h1C, 32'hFFFF_F2A5);
        rd(8'h1C, 32'h0000_02A5, "R8");
        rd(8'h20, 32'h0000_0002, "R10");

        // Writes to read-only, strobe-only and unmapped offsets change nothing
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h40, 32'hFFFF_FFFF);
        rd_all("R10");

        // Disable: count and clock mode kept on that write, accepted afterwards
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, 32'h1012_3400, "R4");
        wr(8'h00, 32'h4855_5500);
        rd(8'h00, 32'h0055_5500, "R9");
        rd(8'h00, 32'h0055_5500, "R6");
        wr(8'h50, 32'hFFFF_FFFF);
        rd(8'h50, 32'hFFFF_5555, "R5");

        // Pseudo-random traffic over all registers
        lfsr = 32'hC0DE_1357;
        for (int k = 0; k < 300; k++) begin
            logic [7:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[2:0])
                3'd0, 3'd1: a = 8'h00;
                3'd2: a = 8'h04;
                3'd3: a = 8'h18;
                3'd4: a = 8'h1C;
                3'd5: a = 8'h50;
                3'd6: a = 8'h08;
                default: a = 8'h44;
            endcase
            wr(a, {lfsr[15:0], lfsr[31:16]} ^ 32'h5A3C_96E1);
            if (k % 5 == 0) rd_all("R9");
        end

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule